// File: doc/BRIEF.md
# Shadow Stack Check Unit

This unit guards return addresses for a simple processor core. It holds a shadow-stack pointer and carries out four operations on a separate, protected stack in memory: pushing a link value, popping the top entry and comparing it with a link value, swapping a register value with the top entry in one atomic access, and reading the pointer back. A return address that does not match the protected copy raises a software-check exception. A shadow-stack access that lands on a read-only page raises a store/AMO page fault. This applies to the pop as well, even though the pop only reads.

The core presents one command at a time together with the link value taken from one of its two link registers. The unit turns the command into at most one request on a simple request/response memory port. Busy stays high until the response comes back. Completion is signalled by a one-cycle `done` pulse that carries the result and any exception. Whether the operations take effect depends on the current privilege level. The enable for user mode comes from the supervisor's configuration, and the enable for supervisor mode comes from the machine's configuration. The pointer is loaded through a dedicated write port while the unit is idle.

Top module: `ssp_guard`

## Requirements
- R1: A push (op code 2'b00) issues one write request at address pointer-4 with the link value as data. On a successful response the pointer becomes pointer-4 and the result is 0.
- R2: A pop-check (op code 2'b01) issues one read request at the current pointer. When the loaded word equals the link value, the pointer becomes pointer+4 and the result is the loaded word.
- R3: A pop-check whose loaded word differs from the link value raises `exc_swcheck` with `done`, leaves the pointer unchanged and returns the loaded word. `exc_swcheck` and `exc_pgfault` are never high together.
- R4: A swap (op code 2'b10) issues one atomic request (`mem_amo`=1, `mem_we`=0) at the current pointer with the link value as data. It returns the old word and leaves the pointer unchanged.
- R5: A read (op code 2'b11) returns the current pointer in the cycle after acceptance and issues no memory request.
- R6: A response with `mem_rsp_ro`=1 raises `exc_pgfault` for every memory operation, the pop-check included. The pointer is left unchanged, the result is 0 and no software-check exception is raised. The memory commits no write for such a response.
- R7: Privilege is encoded as 2'b00 user, 2'b01 supervisor and 2'b11 machine; 2'b10 is treated as machine. User mode is enabled by `en_user` and supervisor mode by `en_super`. Machine mode is never enabled.
- R8: A command issued while disabled makes no memory request. It completes in the cycle after acceptance with result 0, no exception and the pointer unchanged.
- R9: A command is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle the response is taken. `mem_req` is high for exactly one cycle per operation. Commands presented while busy are ignored.
- R10: After reset the pointer is 0 and `busy`, `done`, `mem_req` and both exception outputs are low.
- R11: While idle with no command presented, `ssp_wr_en` loads `ssp_wr_val` into the pointer on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Operation: 00 push, 01 pop-check, 10 swap, 11 read |
| cmd_link | input | XLEN | Link register value |
| priv | input | 2 | Current privilege level |
| en_user | input | 1 | User-mode enable from supervisor configuration |
| en_super | input | 1 | Supervisor-mode enable from machine configuration |
| ssp_wr_en | input | 1 | Pointer load strobe |
| ssp_wr_val | input | XLEN | Pointer load value |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request is a store |
| mem_amo | output | 1 | Request is an atomic swap |
| mem_addr | output | XLEN | Request address |
| mem_wdata | output | XLEN | Store or swap data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_rdata | input | XLEN | Loaded or old word |
| mem_rsp_ro | input | 1 | Page is read-only |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Completion pulse |
| result | output | XLEN | Result of the completed operation |
| exc_swcheck | output | 1 | Software-check exception, with done |
| exc_pgfault | output | 1 | Store/AMO page fault, with done |
| ssp | output | XLEN | Current shadow-stack pointer |

## Verification
A wrong pointer shows on `ssp` and on the next read operation at the `done` pulse of the operation that corrupted it. A later pop then reads the wrong word and mismatches, so the error also surfaces one operation later as a spurious software check. A stuck control state shows as `busy` that never drops, or as a second `mem_req` within one operation, within a few cycles. A fault path that forgets to hold the pointer is visible at the very `done` pulse that reports the fault.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    OP_PUSH   = 2'b00,
    OP_POPCHK = 2'b01,
    OP_SWAP   = 2'b10,
    OP_READ   = 2'b11
  } ss_op_e;

  typedef enum logic [1:0] {
    PRV_U = 2'b00,
    PRV_S = 2'b01,
    PRV_X = 2'b10,
    PRV_M = 2'b11
  } prv_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } ss_state_e;
endpackage

// File: rtl/ssp_mode_gate.sv
module ssp_mode_gate
  import ssp_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       en_user,
  input  logic       en_super,
  output logic       active
);
  // each level takes its enable from the level above it
  always_comb begin
    case (prv_e'(priv))
      PRV_U:   active = en_user;
      PRV_S:   active = en_super;
      default: active = 1'b0;
    endcase
  end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [XLEN-1:0] cmd_link,
  input  logic            active,
  input  logic            ssp_wr_en,
  input  logic [XLEN-1:0] ssp_wr_val,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_amo,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  input  logic            mem_rsp_ro,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            exc_swcheck,
  output logic            exc_pgfault,
  output logic [XLEN-1:0] ssp
);
  localparam int STEP = XLEN / 8;

  function automatic logic [XLEN-1:0] slot_below(input logic [XLEN-1:0] p);
    return p - XLEN'(STEP);
  endfunction

  function automatic logic [XLEN-1:0] slot_above(input logic [XLEN-1:0] p);
    return p + XLEN'(STEP);
  endfunction

  ss_state_e       state_q;
  ss_op_e          op_q;
  logic [XLEN-1:0] link_q, addr_q, ssp_q, result_q;
  logic            done_q, swc_q, pgf_q;

  // named events for the checks below
  logic accept_ev, uses_mem, rsp_take_ev, rsp_fault_ev, rsp_mismatch_ev;
  assign accept_ev       = cmd_valid && (state_q == ST_IDLE);
  assign uses_mem        = active && (ss_op_e'(cmd_op) != OP_READ);
  assign rsp_take_ev     = (state_q == ST_WAIT) && mem_rsp_valid;
  assign rsp_fault_ev    = rsp_take_ev && mem_rsp_ro;
  assign rsp_mismatch_ev = rsp_take_ev && !mem_rsp_ro && (op_q == OP_POPCHK)
                           && (mem_rsp_rdata != link_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_READ;
      link_q   <= '0;
      addr_q   <= '0;
      ssp_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      swc_q    <= 1'b0;
      pgf_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      swc_q  <= 1'b0;
      pgf_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_ev) begin
            op_q   <= ss_op_e'(cmd_op);
            link_q <= cmd_link;
            addr_q <= (ss_op_e'(cmd_op) == OP_PUSH) ? slot_below(ssp_q) : ssp_q;
            if (uses_mem) begin
              state_q <= ST_ISSUE;
            end else begin
              done_q   <= 1'b1;
              result_q <= (active && ss_op_e'(cmd_op) == OP_READ) ? ssp_q : '0;
            end
          end else if (ssp_wr_en) begin
            ssp_q <= ssp_wr_val;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_take_ev) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (rsp_fault_ev) begin
              pgf_q    <= 1'b1;
              result_q <= '0;
            end else begin
              case (op_q)
                OP_PUSH: begin
                  ssp_q    <= addr_q;
                  result_q <= '0;
                end
                OP_POPCHK: begin
                  result_q <= mem_rsp_rdata;
                  if (rsp_mismatch_ev) swc_q <= 1'b1;
                  else                 ssp_q <= slot_above(ssp_q);
                end
                default: result_q <= mem_rsp_rdata;
              endcase
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req     = (state_q == ST_ISSUE);
  assign mem_we      = (op_q == OP_PUSH);
  assign mem_amo     = (op_q == OP_SWAP);
  assign mem_addr    = addr_q;
  assign mem_wdata   = link_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign result      = result_q;
  assign exc_swcheck = swc_q;
  assign exc_pgfault = pgf_q;
  assign ssp         = ssp_q;

  assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  assert_exc_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_swcheck && exc_pgfault));
  assert_fault_holds_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (exc_pgfault || exc_swcheck)) |-> (ssp_q == $past(ssp_q)));
  assert_push_steps_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(state_q == ST_WAIT) && op_q == OP_PUSH && !exc_pgfault)
      |-> (ssp_q == $past(ssp_q) - XLEN'(STEP)));
  assert_pop_steps_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(state_q == ST_WAIT) && op_q == OP_POPCHK && !exc_pgfault && !exc_swcheck)
      |-> (ssp_q == $past(ssp_q) + XLEN'(STEP)));
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && !active) |=> (done && result == '0 && !busy && !mem_req));
endmodule

// File: rtl/ssp_guard.sv
module ssp_guard #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [XLEN-1:0] cmd_link,
  input  logic [1:0]      priv,
  input  logic            en_user,
  input  logic            en_super,
  input  logic            ssp_wr_en,
  input  logic [XLEN-1:0] ssp_wr_val,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_amo,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  input  logic            mem_rsp_ro,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            exc_swcheck,
  output logic            exc_pgfault,
  output logic [XLEN-1:0] ssp
);
  logic mode_active;

  ssp_mode_gate u_gate (
    .priv     (priv),
    .en_user  (en_user),
    .en_super (en_super),
    .active   (mode_active)
  );

  ssp_engine #(.XLEN(XLEN)) u_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_link      (cmd_link),
    .active        (mode_active),
    .ssp_wr_en     (ssp_wr_en),
    .ssp_wr_val    (ssp_wr_val),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_amo       (mem_amo),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .mem_rsp_ro    (mem_rsp_ro),
    .busy          (busy),
    .done          (done),
    .result        (result),
    .exc_swcheck   (exc_swcheck),
    .exc_pgfault   (exc_pgfault),
    .ssp           (ssp)
  );

  assert_machine_never_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && priv[1]) |=> (done && !mem_req));
endmodule

// File: tb/tb_ssp_guard.sv
module tb_ssp_guard;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_op = 2'b11;
  logic [XLEN-1:0] cmd_link = '0;
  logic [1:0]      priv = 2'b00;
  logic            en_user = 1'b1;
  logic            en_super = 1'b0;
  logic            ssp_wr_en = 1'b0;
  logic [XLEN-1:0] ssp_wr_val = '0;
  logic            mem_req, mem_we, mem_amo;
  logic [XLEN-1:0] mem_addr, mem_wdata;
  logic            mem_rsp_valid = 1'b0;
  logic [XLEN-1:0] mem_rsp_rdata = '0;
  logic            mem_rsp_ro = 1'b0;
  logic            busy, done, exc_swcheck, exc_pgfault;
  logic [XLEN-1:0] result, ssp;

  always #10 clk = ~clk;  // 50 MHz

  ssp_guard #(.XLEN(XLEN)) dut (.*);

  int checks = 0;
  int errors = 0;

  // memory model
  logic [XLEN-1:0] mem [64];
  logic            ro_mode = 1'b0;
  int              lat = 1;
  int              cnt = 0;
  int              req_cnt = 0;
  logic [XLEN-1:0] cap_addr, cap_wdata;
  logic            cap_we, cap_amo;

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_ro    = ro_mode;
        mem_rsp_rdata = mem[cap_addr[7:2]];
        if (!ro_mode && (cap_we || cap_amo)) mem[cap_addr[7:2]] = cap_wdata;
      end
    end
    if (mem_req) begin
      req_cnt   = req_cnt + 1;
      cap_addr  = mem_addr;
      cap_wdata = mem_wdata;
      cap_we    = mem_we;
      cap_amo   = mem_amo;
      cnt       = lat;
    end
  end

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [XLEN-1:0] link);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_link = link;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]      op;
    logic [31:0]     link;
    logic [1:0]      prv;
    logic            eu;
    logic            es;
    logic            ro;
    logic [31:0]     res;
    logic [1:0]      exc;   // {swcheck, pgfault}
    logic [31:0]     sp;
    logic [3:0]      req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'hAAAA0001, 2'b00, 1'b1, 1'b0, 1'b0, 32'h0,        2'b00, 32'h3C, 4'd1},  // R1
    '{2'b00, 32'hBBBB0002, 2'b00, 1'b1, 1'b0, 1'b0, 32'h0,        2'b00, 32'h38, 4'd1},  // R1
    '{2'b11, 32'h0,        2'b00, 1'b1, 1'b0, 1'b0, 32'h38,       2'b00, 32'h38, 4'd5},  // R5
    '{2'b01, 32'hBBBB0002, 2'b00, 1'b1, 1'b0, 1'b0, 32'hBBBB0002, 2'b00, 32'h3C, 4'd2},  // R2
    '{2'b01, 32'h12345678, 2'b00, 1'b1, 1'b0, 1'b0, 32'hAAAA0001, 2'b10, 32'h3C, 4'd3},  // R3
    '{2'b10, 32'hCCCC0003, 2'b00, 1'b1, 1'b0, 1'b0, 32'hAAAA0001, 2'b00, 32'h3C, 4'd4},  // R4
    '{2'b01, 32'hCCCC0003, 2'b00, 1'b1, 1'b0, 1'b0, 32'hCCCC0003, 2'b00, 32'h40, 4'd2},  // R2
    '{2'b00, 32'h00000011, 2'b00, 1'b1, 1'b0, 1'b1, 32'h0,        2'b01, 32'h40, 4'd6},  // R6
    '{2'b01, 32'h0,        2'b00, 1'b1, 1'b0, 1'b1, 32'h0,        2'b01, 32'h40, 4'd6},  // R6
    '{2'b00, 32'h00000022, 2'b01, 1'b1, 1'b0, 1'b0, 32'h0,        2'b00, 32'h40, 4'd8},  // R8
    '{2'b11, 32'h0,        2'b01, 1'b0, 1'b1, 1'b0, 32'h40,       2'b00, 32'h40, 4'd7},  // R7
    '{2'b11, 32'h0,        2'b11, 1'b1, 1'b1, 1'b0, 32'h0,        2'b00, 32'h40, 4'd7},  // R7
    '{2'b11, 32'h0,        2'b00, 1'b0, 1'b1, 1'b0, 32'h0,        2'b00, 32'h40, 4'd7},  // R7
    '{2'b11, 32'h0,        2'b10, 1'b1, 1'b1, 1'b0, 32'h0,        2'b00, 32'h40, 4'd7}   // R7
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ssp", ssp, 32'h0);
    chk("R10 busy", {31'h0, busy}, 32'h0);
    chk("R10 done", {31'h0, done}, 32'h0);
    chk("R10 req", {31'h0, mem_req}, 32'h0);
    chk("R10 exc", {30'h0, exc_swcheck, exc_pgfault}, 32'h0);
    rst_n = 1'b1;
    // R11 pointer load
    @(negedge clk); ssp_wr_en = 1'b1; ssp_wr_val = 32'h40;
    @(negedge clk); ssp_wr_en = 1'b0;
    chk("R11 load", ssp, 32'h40);

    for (int v = 0; v < NV; v++) begin
      priv = VECS[v].prv; en_user = VECS[v].eu; en_super = VECS[v].es; ro_mode = VECS[v].ro;
      rc = req_cnt;
      run_op(VECS[v].op, VECS[v].link);
      chk($sformatf("R%0d vec%0d result", VECS[v].req, v), result, VECS[v].res);
      chk($sformatf("R%0d vec%0d exc", VECS[v].req, v), {30'h0, exc_swcheck, exc_pgfault},
          {30'h0, VECS[v].exc});
      chk($sformatf("R%0d vec%0d ssp", VECS[v].req, v), ssp, VECS[v].sp);
      if (VECS[v].op == 2'b11 || VECS[v].req == 4'd8 || VECS[v].req == 4'd7)
        chk($sformatf("R%0d vec%0d no request", VECS[v].req, v), req_cnt - rc, 0);
    end
    ro_mode = 1'b0; priv = 2'b00; en_user = 1'b1;

    // R6: read-only push left memory untouched
    chk("R6 no commit", mem[15], 32'hCCCC0003);

    // R9 + R1: long latency push, command while busy ignored
    lat = 3; rc = req_cnt;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b00; cmd_link = 32'h00005A5A;
    @(negedge clk); cmd_op = 2'b11;
    chk("R9 busy after accept", {31'h0, busy}, 32'h1);
    @(negedge clk); cmd_valid = 1'b0;
    chk("R9 still busy", {31'h0, busy}, 32'h1);
    while (!done) @(negedge clk);
    chk("R9 idle at done", {31'h0, busy}, 32'h0);
    chk("R1 push result", result, 32'h0);
    chk("R1 push ssp", ssp, 32'h3C);
    chk("R1 push addr", cap_addr, 32'h3C);
    chk("R1 push data", cap_wdata, 32'h00005A5A);
    chk("R1 push kind", {30'h0, cap_we, cap_amo}, 32'h2);
    chk("R1 push stored", mem[15], 32'h00005A5A);
    @(negedge clk);
    chk("R9 ignored cmd no done", {31'h0, done}, 32'h0);
    chk("R9 single request", req_cnt - rc, 1);

    // R4 swap request shape
    lat = 2;
    run_op(2'b10, 32'h00000077);
    chk("R4 swap old", result, 32'h00005A5A);
    chk("R4 swap kind", {30'h0, cap_we, cap_amo}, 32'h1);
    chk("R4 swap addr", cap_addr, 32'h3C);
    chk("R4 swap ssp", ssp, 32'h3C);
    chk("R4 swap stored", mem[15], 32'h00000077);

    // R3 mismatch after swap, then R2 correct pop
    run_op(2'b01, 32'h00005A5A);
    chk("R3 mismatch exc", {31'h0, exc_swcheck}, 32'h1);
    chk("R3 mismatch ssp", ssp, 32'h3C);
    run_op(2'b01, 32'h00000077);
    chk("R2 pop ok ssp", ssp, 32'h40);
    chk("R2 pop ok exc", {30'h0, exc_swcheck, exc_pgfault}, 32'h0);

    // R6 swap to read-only page
    ro_mode = 1'b1;
    run_op(2'b10, 32'h99);
    chk("R6 swap fault", {30'h0, exc_swcheck, exc_pgfault}, 32'h1);
    chk("R6 swap ssp", ssp, 32'h40);
    ro_mode = 1'b0;

    // R11 load ignored while busy is not exercised; load when idle again
    @(negedge clk); ssp_wr_en = 1'b1; ssp_wr_val = 32'h80;
    @(negedge clk); ssp_wr_en = 1'b0;
    chk("R11 reload", ssp, 32'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule